// File: doc/BRIEF.md
# Serial-to-Parallel Shift Register Driver

This peripheral feeds an external chain of serial-in, parallel-out shift registers, arranged as up to three groups of eight outputs. Software programs it through a 32-bit register bus. An update serialises a frame onto a data pin, most significant enabled bit first. Each bit gets one pulse of a divided shift clock, and a store pulse then moves the whole chain onto the parallel outputs.

An update starts in one of two ways. Software starts it by writing control word 0 with its update-select bit set. A periodic timer starts it at one of four rates, when software update is deselected and the timer source field selects the bus clock. On timer-driven updates, a few low-order frame bits can be taken per bit from hardware status inputs: two from a line-status source and two from each of two port-status sources. A request that arrives while a frame is being shifted waits and runs as soon as that frame ends.

The engine has four states. IDLE waits for a pending request. SETUP presents a bit with the shift clock at its idle level. CAPTURE drives the clock to its active level. LATCH raises the store line. The transitions are: IDLE to SETUP when a request is pending and at least one group is enabled, and IDLE stays in IDLE, dropping the request, when no group is enabled. SETUP goes to CAPTURE after one half period. CAPTURE goes back to SETUP after one half period when bits remain, and to LATCH after the last bit. LATCH returns to IDLE after one full shift-clock period.

Top module: `sipo_cascade_drv`

## Requirements
- R1: After reset, control 0 (0x00) reads 0x80000000. Control 1 (0x04), data 0 (0x08), data 1 (0x0C) and the access word (0x10) read 0. sr_store is 0 and sr_clk is 0.
- R2: Words written at 0x00, 0x04, 0x08 and 0x0C read back unchanged.
- R3: A write to 0x00 with bit 31 set starts exactly one update from data 0. Reset alone starts none, and neither does a write with bit 31 clear.
- R4: Control 1 bits 2:0 enable groups 0..2. The frame length is 8 × (highest enabled group + 1). Bits shift most significant first, so after the store the chain's outputs [L-1:0] equal frame bits [L-1:0]. With no group enabled, a request produces no clock and no store.
- R5: Control 0 bit 26 = 0 makes sr_clk idle low, and data is captured on its rising edge. A value of 1 makes it idle high, and data is captured on its falling edge. sr_data stays constant while the clock is at its active level.
- R6: After the last bit, sr_store is high for exactly 2 × HALF_DIV cycles while sr_clk sits at its idle level.
- R7: Each level of the shift clock lasts HALF_DIV system cycles, so consecutive capture edges are 2 × HALF_DIV cycles apart.
- R8: With control 0 bit 31 = 0 and control 1 bits 31:30 = 2'b10, updates repeat every UNIT_CYCLES × {20,10,5,4} cycles for rate code (bits 24:23) {0,1,2,3} (2, 4, 8, 10 Hz). Any other source value gives no timer updates.
- R9: On timer updates, frame bit i in 1:0 comes from dsl_in[i] when control 0 bit 24+i is set. Bit 2+i comes from phy1_in[i] when control 0 bit 27+i is set. Bit 5+i comes from phy2_in[i] when control 1 bit 15+i is set. All other bits come from data 0.
- R10: Software updates take every bit from data 0, whatever the hardware enables are.
- R11: A request arriving during an update is kept and runs right after it, using the register contents at its start.
- R12: Access word bit 0 reads 1 while an update is active or pending, and 0 otherwise. Writes to the access word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| dsl_in | input | 2 | Line-status hardware inputs |
| phy1_in | input | 2 | First port-status hardware inputs |
| phy2_in | input | 2 | Second port-status hardware inputs |
| sr_data | output | 1 | Serial data to the chain |
| sr_clk | output | 1 | Shift clock to the chain |
| sr_store | output | 1 | Store/latch strobe to the chain |

## Verification
The assertions assume the bus and the hardware status inputs are synchronous to clk and change only between rising edges. They also assume the edge-select bit is not rewritten during an active frame, since the clock-idle checks compare against its live value. The bench drives every input at falling edges. It changes the edge setting only in the same write that starts a frame, while the engine is idle. It waits for the busy bit to clear before it reconfigures anything. The timer runs with a small UNIT_CYCLES, so all four rates are measured as cycle intervals.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CAPTURE,
        ST_LATCH
    } shift_state_t;

    localparam logic [4:0] ADDR_CTL0 = 5'h00;
    localparam logic [4:0] ADDR_CTL1 = 5'h04;
    localparam logic [4:0] ADDR_DAT0 = 5'h08;
    localparam logic [4:0] ADDR_DAT1 = 5'h0C;
    localparam logic [4:0] ADDR_ACC  = 5'h10;

    localparam int SW_SEL_BIT  = 31;
    localparam int EDGE_BIT    = 26;
    localparam int DSL_LSB     = 24;
    localparam int PHY1_LSB    = 27;
    localparam int PHY2_LSB    = 15;
    localparam int RATE_LSB    = 23;
    localparam int SRC_LSB     = 30;
    localparam logic [1:0] SRC_BUSCLK = 2'b10;

    localparam int HW_W      = 2;
    localparam int DSL_BASE  = 0;
    localparam int PHY1_BASE = 2;
    localparam int PHY2_BASE = 5;

    localparam logic [31:0] CTL0_RESET = 32'h8000_0000;
endpackage

// File: rtl/sipo_regs.sv
module sipo_regs
    import sipo_pkg::*;
#(
    parameter int NGROUP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    output logic [31:0]       cpu_word,
    output logic              sw_req,
    output logic              sw_mode,
    output logic              edge_sel,
    output logic [HW_W-1:0]   dsl_en,
    output logic [HW_W-1:0]   phy1_en,
    output logic [HW_W-1:0]   phy2_en,
    output logic [NGROUP-1:0] group_en,
    output logic [1:0]        rate_sel,
    output logic [1:0]        src_sel
);
    logic [31:0] ctl0_q, ctl1_q, dat0_q, dat1_q;
    logic        wr_en;

    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0_q <= CTL0_RESET;
            ctl1_q <= '0;
            dat0_q <= '0;
            dat1_q <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                ADDR_CTL0: ctl0_q <= bus_wdata;
                ADDR_CTL1: ctl1_q <= bus_wdata;
                ADDR_DAT0: dat0_q <= bus_wdata;
                ADDR_DAT1: dat1_q <= bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTL0: bus_rdata = ctl0_q;
            ADDR_CTL1: bus_rdata = ctl1_q;
            ADDR_DAT0: bus_rdata = dat0_q;
            ADDR_DAT1: bus_rdata = dat1_q;
            ADDR_ACC:  bus_rdata = {31'd0, busy};
            default:   bus_rdata = '0;
        endcase
    end

    assign sw_req   = wr_en && (bus_addr == ADDR_CTL0) && bus_wdata[SW_SEL_BIT];
    assign cpu_word = dat0_q;
    assign sw_mode  = ctl0_q[SW_SEL_BIT];
    assign edge_sel = ctl0_q[EDGE_BIT];
    assign dsl_en   = ctl0_q[DSL_LSB +: HW_W];
    assign phy1_en  = ctl0_q[PHY1_LSB +: HW_W];
    assign phy2_en  = ctl1_q[PHY2_LSB +: HW_W];
    assign group_en = ctl1_q[NGROUP-1:0];
    assign rate_sel = ctl1_q[RATE_LSB +: 2];
    assign src_sel  = ctl1_q[SRC_LSB +: 2];

    assert_ctl0_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr == ADDR_CTL0) |=> $stable(ctl0_q));
    assert_dat0_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr == ADDR_DAT0) |=> $stable(cpu_word));
endmodule

// File: rtl/sipo_rate_timer.sv
module sipo_rate_timer #(
    parameter int UNIT_CYCLES = 3_125_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int MAX_PERIOD = UNIT_CYCLES * 20;
    localparam int CW = $clog2(MAX_PERIOD + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period;

    always_comb begin
        unique case (rate_sel)
            2'd0: period = CW'(UNIT_CYCLES * 20);
            2'd1: period = CW'(UNIT_CYCLES * 10);
            2'd2: period = CW'(UNIT_CYCLES * 5);
            default: period = CW'(UNIT_CYCLES * 4);
        endcase
    end

    assign tick = en && (cnt_q >= period - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt_q <= '0;
        else cnt_q <= cnt_q + CW'(1);
    end

    assert_tick_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
    assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0) && !tick);
endmodule

// File: rtl/sipo_shift_fsm.sv
module sipo_shift_fsm
    import sipo_pkg::*;
#(
    parameter int NGROUP   = 3,
    parameter int GROUP_W  = 8,
    parameter int HALF_DIV = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NGROUP-1:0]          group_en,
    input  logic                       edge_sel,
    input  logic                       req,
    input  logic                       req_hw,
    input  logic [NGROUP*GROUP_W-1:0]  frame_sw,
    input  logic [NGROUP*GROUP_W-1:0]  frame_hw,
    output logic                       busy,
    output logic                       sr_data,
    output logic                       sr_clk,
    output logic                       sr_store
);
    localparam int FRAME_W = NGROUP * GROUP_W;
    localparam int LW      = $clog2(FRAME_W + 1);
    localparam int TW      = $clog2(2 * HALF_DIV) > 0 ? $clog2(2 * HALF_DIV) : 1;

    shift_state_t state_q, state_d;
    logic [FRAME_W-1:0] shreg_q;
    logic [LW-1:0]      bits_left_q;
    logic [LW-1:0]      frame_len;
    logic [TW-1:0]      tmr_q;
    logic               pend_q, pend_hw_q;
    logic               start, drop, tmr_zero;

    always_comb begin
        frame_len = '0;
        for (int g = 0; g < NGROUP; g++) begin
            if (group_en[g]) frame_len = LW'((g + 1) * GROUP_W);
        end
    end

    assign tmr_zero = (tmr_q == '0);
    assign start    = (state_q == ST_IDLE) && pend_q && (frame_len != '0);
    assign drop     = (state_q == ST_IDLE) && pend_q && (frame_len == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_SETUP;
            ST_SETUP:   if (tmr_zero) state_d = ST_CAPTURE;
            ST_CAPTURE: if (tmr_zero) state_d = (bits_left_q == '0) ? ST_LATCH : ST_SETUP;
            ST_LATCH:   if (tmr_zero) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            shreg_q     <= '0;
            bits_left_q <= '0;
            tmr_q       <= '0;
            pend_q      <= 1'b0;
            pend_hw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= ((start || drop) ? 1'b0 : pend_q) | req;
            if (req) pend_hw_q <= req_hw;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        shreg_q     <= (pend_hw_q ? frame_hw : frame_sw) << (LW'(FRAME_W) - frame_len);
                        bits_left_q <= frame_len - LW'(1);
                        tmr_q       <= TW'(HALF_DIV - 1);
                    end
                end
                ST_SETUP: begin
                    tmr_q <= tmr_zero ? TW'(HALF_DIV - 1) : tmr_q - TW'(1);
                end
                ST_CAPTURE: begin
                    if (tmr_zero) begin
                        if (bits_left_q == '0) begin
                            tmr_q <= TW'(2 * HALF_DIV - 1);
                        end else begin
                            shreg_q     <= shreg_q << 1;
                            bits_left_q <= bits_left_q - LW'(1);
                            tmr_q       <= TW'(HALF_DIV - 1);
                        end
                    end else begin
                        tmr_q <= tmr_q - TW'(1);
                    end
                end
                ST_LATCH: begin
                    if (!tmr_zero) tmr_q <= tmr_q - TW'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE) || pend_q;
        sr_data  = (state_q != ST_IDLE) && shreg_q[FRAME_W-1];
        sr_clk   = (state_q == ST_CAPTURE) ^ edge_sel;
        sr_store = (state_q == ST_LATCH);
    end

    assert_store_clk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_store |-> (sr_clk == edge_sel));
    assert_store_min_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_store) |=> sr_store);
    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && $past(state_q) == ST_CAPTURE) |-> $stable(sr_data));
    assert_bits_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (bits_left_q < LW'(FRAME_W)));
    assert_quiet_when_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sr_store && !sr_data);
endmodule

// File: rtl/sipo_cascade_drv.sv
module sipo_cascade_drv
    import sipo_pkg::*;
#(
    parameter int NGROUP      = 3,
    parameter int GROUP_W     = 8,
    parameter int HALF_DIV    = 4,
    parameter int UNIT_CYCLES = 3_125_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  dsl_in,
    input  logic [1:0]  phy1_in,
    input  logic [1:0]  phy2_in,
    output logic        sr_data,
    output logic        sr_clk,
    output logic        sr_store
);
    localparam int FRAME_W = NGROUP * GROUP_W;

    logic [31:0]        cpu_word;
    logic               sw_req, sw_mode, edge_sel, busy, tick, timer_en;
    logic [HW_W-1:0]    dsl_en, phy1_en, phy2_en;
    logic [NGROUP-1:0]  group_en;
    logic [1:0]         rate_sel, src_sel;
    logic [FRAME_W-1:0] frame_sw, frame_hw;

    sipo_regs #(.NGROUP(NGROUP)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .cpu_word(cpu_word), .sw_req(sw_req), .sw_mode(sw_mode),
        .edge_sel(edge_sel), .dsl_en(dsl_en), .phy1_en(phy1_en), .phy2_en(phy2_en),
        .group_en(group_en), .rate_sel(rate_sel), .src_sel(src_sel)
    );

    assign timer_en = !sw_mode && (src_sel == SRC_BUSCLK);

    sipo_rate_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(timer_en), .rate_sel(rate_sel), .tick(tick)
    );

    assign frame_sw = cpu_word[FRAME_W-1:0];

    for (genvar b = 0; b < FRAME_W; b++) begin : g_src_mux
        if (b >= DSL_BASE && b < DSL_BASE + HW_W) begin : g_dsl
            assign frame_hw[b] = dsl_en[b-DSL_BASE] ? dsl_in[b-DSL_BASE] : cpu_word[b];
        end else if (b >= PHY1_BASE && b < PHY1_BASE + HW_W) begin : g_phy1
            assign frame_hw[b] = phy1_en[b-PHY1_BASE] ? phy1_in[b-PHY1_BASE] : cpu_word[b];
        end else if (b >= PHY2_BASE && b < PHY2_BASE + HW_W) begin : g_phy2
            assign frame_hw[b] = phy2_en[b-PHY2_BASE] ? phy2_in[b-PHY2_BASE] : cpu_word[b];
        end else begin : g_cpu
            assign frame_hw[b] = cpu_word[b];
        end
    end

    sipo_shift_fsm #(.NGROUP(NGROUP), .GROUP_W(GROUP_W), .HALF_DIV(HALF_DIV)) u_fsm (
        .clk(clk), .rst_n(rst_n), .group_en(group_en), .edge_sel(edge_sel),
        .req(sw_req || tick), .req_hw(tick && !sw_req),
        .frame_sw(frame_sw), .frame_hw(frame_hw), .busy(busy),
        .sr_data(sr_data), .sr_clk(sr_clk), .sr_store(sr_store)
    );

    assert_no_tick_in_sw_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mode |-> !tick);
endmodule

// File: tb/sipo_cascade_drv_test.sv
`timescale 1ns/1ps
module sipo_cascade_drv_test;
    localparam int HALF = 2;
    localparam int UNIT = 10;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [4:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [1:0] dsl_in = 0, phy1_in = 0, phy2_in = 0;
    logic sr_data, sr_clk, sr_store;

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    int edge_mode = 0;
    int n_cap = 0, n_store = 0, bad_gap = 0;
    int last_cap_t = -1, store_rise_t = 0, store_prev_t = 0, store_w = 0;
    logic [23:0] ext = 0, par = 0;
    logic [31:0] rv;
    bit done = 0;

    sipo_cascade_drv #(.HALF_DIV(HALF), .UNIT_CYCLES(UNIT)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dsl_in(dsl_in), .phy1_in(phy1_in), .phy2_in(phy2_in),
        .sr_data(sr_data), .sr_clk(sr_clk), .sr_store(sr_store)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic capture();
        if (last_cap_t >= 0 && (cyc - last_cap_t) != 2*HALF) bad_gap++;
        last_cap_t = cyc;
        ext = {ext[22:0], sr_data};
        n_cap++;
    endtask
    always @(posedge sr_clk) if (edge_mode == 0 && rst_n) capture();
    always @(negedge sr_clk) if (edge_mode == 1 && rst_n) capture();
    always @(posedge sr_store) begin
        par = ext; n_store++;
        store_prev_t = store_rise_t; store_rise_t = cyc;
    end
    always @(negedge sr_store) store_w = cyc - store_rise_t;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] b;
        for (int k = 0; k < 3000; k++) begin
            rd(5'h10, b);
            if (b[0] == 1'b0) return;
        end
        check(0, "R12 busy never cleared", 1, 0);
    endtask

    task automatic reset_mon();
        n_cap = 0; n_store = 0; bad_gap = 0; last_cap_t = -1; ext = 0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(5'h00, rv); check(rv == 32'h8000_0000, "R1 ctl0 reset", rv, 32'h8000_0000);
        rd(5'h04, rv); check(rv == 0, "R1 ctl1 reset", rv, 0);
        rd(5'h08, rv); check(rv == 0, "R1 data0 reset", rv, 0);
        rd(5'h0C, rv); check(rv == 0, "R1 data1 reset", rv, 0);
        rd(5'h10, rv); check(rv == 0, "R1 access reset", rv, 0);
        check(sr_store == 0 && sr_clk == 0, "R1 pins reset", {sr_store, sr_clk}, 0);
        // R3 no update from reset alone
        repeat (50) @(negedge clk);
        check(n_store == 0, "R3 no update after reset", n_store, 0);

        // R2 readback
        wr(5'h04, 32'h4181_8007); rd(5'h04, rv); check(rv == 32'h4181_8007, "R2 ctl1", rv, 32'h4181_8007);
        wr(5'h0C, 32'h1234_5678); rd(5'h0C, rv); check(rv == 32'h1234_5678, "R2 data1", rv, 32'h1234_5678);
        wr(5'h08, 32'hCAFE_F00D); rd(5'h08, rv); check(rv == 32'hCAFE_F00D, "R2 data0", rv, 32'hCAFE_F00D);
        wr(5'h00, 32'h0400_0000); rd(5'h00, rv); check(rv == 32'h0400_0000, "R2 ctl0", rv, 32'h0400_0000);
        edge_mode = 0;
        wr(5'h00, 32'h0000_0000);
        // R3 bit31 clear: no update; R8 source 01 gives no timer updates
        reset_mon(); repeat (300) @(negedge clk);
        check(n_store == 0, "R3 R8 no update without trigger", n_store, 0);

        // R4 R5 R6 R7 sweep over groups and edge
        for (int e = 0; e < 2; e++) begin
            for (int g = 1; g < 8; g++) begin
                int len;
                logic [31:0] d;
                len = (g >= 4) ? 24 : (g >= 2) ? 16 : 8;
                d = 32'h00A5_C396 ^ (g * 32'h0013_1F07) ^ (e * 32'h00FF_0F0F);
                wr(5'h08, d);
                wr(5'h04, g);
                reset_mon();
                edge_mode = e;
                wr(5'h00, 32'h8000_0000 | (e << 26));
                wait_idle();
                check(n_cap == len && n_store == 1, "R4 bit count", n_cap, len);
                check((par & ((24'd1 << len) - 1)) == (d[23:0] & ((24'd1 << len) - 1)), "R4 R5 frame", par, d[23:0]);
                check(bad_gap == 0, "R7 capture spacing", bad_gap, 0);
                check(store_w == 2*HALF, "R6 store width", store_w, 2*HALF);
                check(sr_clk == e, "R5 idle level", sr_clk, e);
            end
        end
        edge_mode = 0;
        wr(5'h00, 32'h0000_0000);

        // R4 no group enabled
        wr(5'h04, 0); reset_mon();
        wr(5'h00, 32'h8000_0000); wait_idle(); repeat (20) @(negedge clk);
        check(n_cap == 0 && n_store == 0, "R4 zero groups", n_cap + n_store, 0);

        // R11 pending request and R12 busy
        wr(5'h04, 1); reset_mon();
        wr(5'h08, 32'h0000_003C); wr(5'h00, 32'h8000_0000);
        rd(5'h10, rv); check(rv == 1, "R12 busy during shift", rv, 1);
        wr(5'h08, 32'h0000_00C3); wr(5'h00, 32'h8000_0000);
        wait_idle();
        check(n_store == 2, "R11 two updates", n_store, 2);
        check(par[7:0] == 8'hC3, "R11 second frame", par[7:0], 8'hC3);
        wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, rv); check(rv == 0, "R12 access write ignored", rv, 0);

        // R10 software update ignores hardware sources
        dsl_in = 2'b11; phy1_in = 2'b11; phy2_in = 2'b11;
        wr(5'h08, 32'h0000_0000); wr(5'h04, 32'h0001_8001);
        reset_mon(); wr(5'h00, 32'h9B00_0000); wait_idle();
        check(par[7:0] == 8'h00, "R10 sw uses data only", par[7:0], 0);

        // R9 hardware muxing on timer updates
        begin
            logic [7:0] d, exp;
            logic [1:0] de, p1e, p2e;
            d = 8'h5A; de = 2'b11; p1e = 2'b01; p2e = 2'b11;
            dsl_in = 2'b01; phy1_in = 2'b01; phy2_in = 2'b00;
            exp = d;
            for (int i = 0; i < 2; i++) begin
                if (de[i])  exp[i]   = dsl_in[i];
                if (p1e[i]) exp[2+i] = phy1_in[i];
                if (p2e[i]) exp[5+i] = phy2_in[i];
            end
            wr(5'h08, {24'd0, d});
            wr(5'h00, {3'b000, p1e, 1'b0, de, 24'd0});
            reset_mon();
            wr(5'h04, 32'h8001_8001 | (32'd3 << 23));
            while (n_store < 1) @(negedge clk);
            wr(5'h04, 32'h0000_0001); wait_idle();
            check(par[7:0] == exp, "R9 hw mux frame", par[7:0], exp);
        end

        // R8 rate intervals
        wr(5'h00, 32'h0000_0000);
        for (int r = 0; r < 4; r++) begin
            int per;
            per = UNIT * ((r == 0) ? 20 : (r == 1) ? 10 : (r == 2) ? 5 : 4);
            reset_mon();
            wr(5'h04, 32'h8000_0001 | (r << 23));
            while (n_store < 3) @(negedge clk);
            check(store_rise_t - store_prev_t == per, "R8 update interval", store_rise_t - store_prev_t, per);
            wr(5'h04, 32'h0000_0001); wait_idle();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule